// File: doc/BRIEF.md
# Buffer-to-Buffer Streaming FIR Engine

This block is a bus-master accelerator that filters one byte buffer per run. A host loads a source base address, a destination base address, a buffer length in bytes, a packet ordering flag and a repeat count, then pulses `start`. The engine fetches the source buffer one fixed-size burst ("packet") at a time over a simple burst read channel. It queues the beats in an input FIFO and runs them through a 4-tap FIR over 8-bit samples. The results gather in an output FIFO and are written back over a burst write channel to the matching location in the destination buffer.

A packet is 16 beats of 64 bits (128 bytes). Packets are visited either in linear order or in an order where the packet index is bit-reversed over the number of index bits the buffer needs. The whole read-filter-write pass runs as many times as programmed. When the last write response of the final pass arrives, the engine raises `done`, pulses `irq` and freezes a cycle counter that measured the run. A buffer length that is not a power of two, or that is smaller than one packet, sets `err` and starts nothing.

Top module: `strm_fir_dma`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `irq`, `ar_valid`, `aw_valid` and `w_valid` are 0 and `cycles` is 0.
- R2: A `start` pulse while idle with a legal length sets `busy` on the next cycle. Each packet is then fetched with one read address request, 128-byte aligned relative to `src_base`, followed by 16 beats. A read address held without `ar_ready` keeps its value.
- R3: With `rev_order`=0, the j-th packet of a pass is read from `src_base + j*128` and its results are written to `dst_base + j*128`.
- R4: With `rev_order`=1, the j-th packet uses offset `rev_k(j)*128` for both reading and writing. `rev_k` reverses the low k bits of j, with k = log2(length/128).
- R5: Byte lane 0 (bits 7:0) of a beat is the earliest sample, and the samples run on across beats and packets in processing order. Output sample y[n] = min(255, (x[n] + 3x[n-1] + 3x[n-2] + x[n-3]) >> 3). Samples before the start of each pass count as 0.
- R6: A write address is issued only once 16 filtered beats are buffered. Each write burst has exactly 16 beats, with `w_last` on the 16th, and there is exactly one write burst per packet.
- R7: A read address is issued only if the input FIFO has room for a whole burst. With writes blocked, exactly 4 read bursts are accepted before reading stalls.
- R8: A pass repeats `pass_total` times, so the run issues `pass_total` × (length/128) read bursts. A `pass_total` of 0 runs one pass.
- R9: After the last write response of the final pass, `busy` drops, `done` rises and `irq` is high for exactly one cycle.
- R10: `cycles` clears when a run is accepted, counts each clock edge while `busy`, and then holds. At `done` it equals the number of edges from the accepting edge to the edge that raised `done`.
- R11: A length that is not a power of two, or is below 128, sets `err` on the next cycle. `busy` and `done` stay 0 and no read is requested. A later legal start clears `err`.
- R12: `start` and configuration changes while `busy` have no effect on the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, taken only when idle |
| src_base | input | 32 | Source buffer base address |
| dst_base | input | 32 | Destination buffer base address |
| xfer_bytes | input | 22 | Buffer length in bytes |
| rev_order | input | 1 | 1 = bit-reversed packet order |
| pass_total | input | 8 | Number of passes (0 acts as 1) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, cleared by next start |
| err | output | 1 | Illegal length at last start |
| irq | output | 1 | One-cycle completion pulse |
| cycles | output | 32 | Elapsed cycle count of the run |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | 32 | Read burst address |
| r_valid | input | 1 | Read beat valid |
| r_ready | output | 1 | Read beat accepted |
| r_data | input | 64 | Read beat data |
| r_last | input | 1 | Final beat of read burst |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address accepted |
| aw_addr | output | 32 | Write burst address |
| w_valid | output | 1 | Write beat valid |
| w_ready | input | 1 | Write beat accepted |
| w_data | output | 64 | Write beat data |
| w_last | output | 1 | Final beat of write burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response accepted |

## Verification
The filter is run in several configurations:
- A one-packet buffer shows that no address bits are left over when k = 0.
- A 4 KB linear run with random bus stalls and a long write blockade checks FIFO back-pressure.
- A 4 KB bit-reversed run tells the reversal apart from linear order, because only the exact reversed offsets match.
- A three-pass bit-reversed run, with a second start mid-run, detects history that is not cleared at a pass boundary and any restart or reconfiguration leaking in.
- Runs with zero passes and with illegal lengths cover the count and rejection corners.

The bench compares every destination byte with its own filter model.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_ADDR = 2'd1,
      RD_DATA = 2'd2
   } rd_ph_e;

   typedef enum logic [1:0] {
      WR_IDLE = 2'd0,
      WR_ADDR = 2'd1,
      WR_DATA = 2'd2,
      WR_RESP = 2'd3
   } wr_ph_e;
endpackage

// File: rtl/sfa_fifo.sv
module sfa_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 32,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("sfa_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[rd_ptr];
endmodule

// File: rtl/sfa_pkt_map.sv
module sfa_pkt_map #(
   parameter int IDX_W = 14,
   localparam int NB_W = $clog2(IDX_W + 1)
) (
   input  logic [IDX_W-1:0] idx,
   input  logic [NB_W-1:0]  nbits,
   input  logic             rev_en,
   output logic [IDX_W-1:0] off
);
   logic [IDX_W-1:0] full_rev;

   // Reverse across the full width, then slide the live bits back down.
   generate
      for (genvar b = 0; b < IDX_W; b++) begin : g_rev
         assign full_rev[b] = idx[IDX_W-1-b];
      end
   endgenerate

   always_comb begin
      if (rev_en) off = full_rev >> (IDX_W - int'(nbits));
      else        off = idx;
   end
endmodule

// File: rtl/sfa_fir_beat.sv
module sfa_fir_beat #(
   parameter int LANES = 8,
   parameter int SW    = 8,
   parameter int SHIFT = 3,
   parameter int C0    = 1,
   parameter int C1    = 3,
   parameter int C2    = 3,
   parameter int C3    = 1,
   localparam int CSUM  = C0 + C1 + C2 + C3,
   localparam int ACC_W = SW + $clog2(CSUM + 1),
   localparam int MAXV  = (1 << SW) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic [LANES*SW-1:0] din,
   output logic [LANES*SW-1:0] dout
);
   generate
      if (LANES < 3) begin : g_bad_lanes
         $error("sfa_fir_beat: at least 3 lanes per beat are needed");
      end
   endgenerate

   logic [SW-1:0] hist [3];
   logic [SW-1:0] ext  [LANES+3];

   generate
      for (genvar k = 0; k < 3; k++) begin : g_hist
         assign ext[k] = hist[k];
      end
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [ACC_W-1:0] acc, sh;
         assign ext[i+3] = din[i*SW +: SW];
         assign acc = ACC_W'(C0) * ACC_W'(ext[i+3]) + ACC_W'(C1) * ACC_W'(ext[i+2])
                    + ACC_W'(C2) * ACC_W'(ext[i+1]) + ACC_W'(C3) * ACC_W'(ext[i]);
         assign sh = acc >> SHIFT;
         assign dout[i*SW +: SW] = (sh > ACC_W'(MAXV)) ? SW'(MAXV) : sh[SW-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 3; k++) hist[k] <= '0;
      end else if (clr) begin
         for (int k = 0; k < 3; k++) hist[k] <= '0;
      end else if (adv) begin
         hist[0] <= din[(LANES-3)*SW +: SW];
         hist[1] <= din[(LANES-2)*SW +: SW];
         hist[2] <= din[(LANES-1)*SW +: SW];
      end
   end
endmodule

// File: rtl/strm_fir_dma.sv
module strm_fir_dma
   import sfa_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 64,
   parameter int BEATS       = 16,
   parameter int SIZE_W      = 22,
   parameter int PASS_W      = 8,
   parameter int CYC_W       = 32,
   parameter int FIFO_BURSTS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [SIZE_W-1:0] xfer_bytes,
   input  logic              rev_order,
   input  logic [PASS_W-1:0] pass_total,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              irq,
   output logic [CYC_W-1:0]  cycles,
   output logic              ar_valid,
   input  logic              ar_ready,
   output logic [ADDR_W-1:0] ar_addr,
   input  logic              r_valid,
   output logic              r_ready,
   input  logic [DATA_W-1:0] r_data,
   input  logic              r_last,
   output logic              aw_valid,
   input  logic              aw_ready,
   output logic [ADDR_W-1:0] aw_addr,
   output logic              w_valid,
   input  logic              w_ready,
   output logic [DATA_W-1:0] w_data,
   output logic              w_last,
   input  logic              b_valid,
   output logic              b_ready
);
   localparam int LANES      = DATA_W / 8;
   localparam int PKT_BYTES  = BEATS * LANES;
   localparam int PKT_LOG2   = $clog2(PKT_BYTES);
   localparam int PIDX_W     = SIZE_W - 1 - PKT_LOG2;
   localparam int PK_W       = PIDX_W + 1;
   localparam int NB_W       = $clog2(PIDX_W + 1);
   localparam int LG_W       = $clog2(SIZE_W + 1);
   localparam int FIFO_DEPTH = BEATS * FIFO_BURSTS;
   localparam int FCNT_W     = $clog2(FIFO_DEPTH + 1);
   localparam int BC_W       = $clog2(BEATS);

   generate
      if ((DATA_W % 8) != 0) begin : g_bad_dw
         $error("strm_fir_dma: DATA_W must be a whole number of bytes");
      end
      if ((BEATS < 2) || ((BEATS & (BEATS - 1)) != 0)) begin : g_bad_beats
         $error("strm_fir_dma: BEATS must be a power of two of at least 2");
      end
      if (FIFO_BURSTS < 2) begin : g_bad_fb
         $error("strm_fir_dma: FIFO_BURSTS must be at least 2");
      end
      if (PIDX_W < 1) begin : g_bad_size
         $error("strm_fir_dma: SIZE_W too small for one packet");
      end
   endgenerate

   // ---------------- length decode ----------------
   logic [SIZE_W-1:0] sz_m1;
   logic [LG_W-1:0]   lg;
   logic              size_ok;

   assign sz_m1   = xfer_bytes - 1'b1;
   assign size_ok = (xfer_bytes != '0) && ((xfer_bytes & sz_m1) == '0)
                    && (xfer_bytes >= SIZE_W'(PKT_BYTES));

   always_comb begin
      lg = '0;
      for (int i = 0; i < SIZE_W; i++) begin
         if (xfer_bytes[i]) lg = LG_W'(i);
      end
   end

   // ---------------- state ----------------
   logic              busy_q, done_q, err_q, irq_q;
   logic [CYC_W-1:0]  cyc_q;
   logic [ADDR_W-1:0] src_q, dst_q;
   logic [NB_W-1:0]   nbits_q;
   logic [PK_W-1:0]   npk_q, rd_pk, wr_pk;
   logic              rev_q;
   logic [PASS_W-1:0] passes_q, pass_q;
   logic [BC_W-1:0]   wbeat;
   rd_ph_e            rd_ph;
   wr_ph_e            wr_ph;

   logic [NB_W-1:0]   nbits_d;
   logic              accept, last_pass, pass_adv, rd_go, fir_go;
   logic [FCNT_W-1:0] in_cnt, out_cnt;
   logic [DATA_W-1:0] in_head, fir_out;
   logic [PIDX_W-1:0] rd_off, wr_off;

   assign nbits_d   = NB_W'(lg - LG_W'(PKT_LOG2));
   assign accept    = start && !busy_q;
   assign last_pass = ({1'b0, pass_q} + 1'b1) >= {1'b0, passes_q};
   assign pass_adv  = (wr_ph == WR_RESP) && b_valid && (wr_pk == npk_q) && !last_pass;
   assign rd_go     = busy_q && (rd_ph == RD_IDLE) && (rd_pk < npk_q)
                      && (in_cnt <= FCNT_W'(FIFO_DEPTH - BEATS));
   assign fir_go    = (in_cnt != '0) && (out_cnt != FCNT_W'(FIFO_DEPTH));

   // ---------------- packet address mapping ----------------
   sfa_pkt_map #(.IDX_W(PIDX_W)) u_rd_map (
      .idx   (rd_pk[PIDX_W-1:0]),
      .nbits (nbits_q),
      .rev_en(rev_q),
      .off   (rd_off)
   );

   sfa_pkt_map #(.IDX_W(PIDX_W)) u_wr_map (
      .idx   (wr_pk[PIDX_W-1:0]),
      .nbits (nbits_q),
      .rev_en(rev_q),
      .off   (wr_off)
   );

   // ---------------- datapath ----------------
   sfa_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_in_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (r_valid && r_ready),
      .din  (r_data),
      .pop  (fir_go),
      .dout (in_head),
      .count(in_cnt)
   );

   sfa_fir_beat #(.LANES(LANES), .SW(8), .SHIFT(3),
                  .C0(1), .C1(3), .C2(3), .C3(1)) u_fir (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  ((accept && size_ok) || pass_adv),
      .adv  (fir_go),
      .din  (in_head),
      .dout (fir_out)
   );

   sfa_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_out_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .push (fir_go),
      .din  (fir_out),
      .pop  (w_valid && w_ready),
      .dout (w_data),
      .count(out_cnt)
   );

   // ---------------- control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         irq_q    <= 1'b0;
         cyc_q    <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         nbits_q  <= '0;
         npk_q    <= '0;
         rev_q    <= 1'b0;
         passes_q <= '0;
         pass_q   <= '0;
         rd_pk    <= '0;
         wr_pk    <= '0;
         wbeat    <= '0;
         rd_ph    <= RD_IDLE;
         wr_ph    <= WR_IDLE;
      end else begin
         irq_q <= 1'b0;
         if (busy_q) cyc_q <= cyc_q + 1'b1;

         unique case (rd_ph)
            RD_IDLE: if (rd_go) rd_ph <= RD_ADDR;
            RD_ADDR: if (ar_ready) begin
               rd_ph <= RD_DATA;
               rd_pk <= rd_pk + 1'b1;
            end
            RD_DATA: if (r_valid && r_last) rd_ph <= RD_IDLE;
            default: rd_ph <= RD_IDLE;
         endcase

         unique case (wr_ph)
            WR_IDLE: if (busy_q && (out_cnt >= FCNT_W'(BEATS))) wr_ph <= WR_ADDR;
            WR_ADDR: if (aw_ready) begin
               wr_ph <= WR_DATA;
               wr_pk <= wr_pk + 1'b1;
               wbeat <= '0;
            end
            WR_DATA: if (w_ready) begin
               wbeat <= wbeat + 1'b1;
               if (wbeat == BC_W'(BEATS - 1)) wr_ph <= WR_RESP;
            end
            WR_RESP: if (b_valid) begin
               wr_ph <= WR_IDLE;
               if (wr_pk == npk_q) begin
                  if (last_pass) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                     irq_q  <= 1'b1;
                  end else begin
                     pass_q <= pass_q + 1'b1;
                     rd_pk  <= '0;
                     wr_pk  <= '0;
                  end
               end
            end
            default: wr_ph <= WR_IDLE;
         endcase

         if (accept) begin
            done_q <= 1'b0;
            if (size_ok) begin
               busy_q   <= 1'b1;
               err_q    <= 1'b0;
               cyc_q    <= '0;
               src_q    <= src_base;
               dst_q    <= dst_base;
               nbits_q  <= nbits_d;
               npk_q    <= PK_W'(1) << nbits_d;
               rev_q    <= rev_order;
               passes_q <= pass_total;
               pass_q   <= '0;
               rd_pk    <= '0;
               wr_pk    <= '0;
            end else begin
               err_q <= 1'b1;
            end
         end
      end
   end

   assign busy     = busy_q;
   assign done     = done_q;
   assign err      = err_q;
   assign irq      = irq_q;
   assign cycles   = cyc_q;
   assign ar_valid = (rd_ph == RD_ADDR);
   assign ar_addr  = src_q + (ADDR_W'(rd_off) << PKT_LOG2);
   assign r_ready  = (rd_ph == RD_DATA);
   assign aw_valid = (wr_ph == WR_ADDR);
   assign aw_addr  = dst_q + (ADDR_W'(wr_off) << PKT_LOG2);
   assign w_valid  = (wr_ph == WR_DATA);
   assign w_last   = (wr_ph == WR_DATA) && (wbeat == BC_W'(BEATS - 1));
   assign b_ready  = (wr_ph == WR_RESP);
endmodule

// File: rtl/strm_fir_dma_chk.sv
module strm_fir_dma_chk #(
   parameter int ADDR_W     = 32,
   parameter int BEATS      = 16,
   parameter int FIFO_DEPTH = 32,
   parameter int FCNT_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              irq,
   input logic              ar_valid,
   input logic              ar_ready,
   input logic [ADDR_W-1:0] ar_addr,
   input logic              aw_valid,
   input logic              aw_ready,
   input logic [ADDR_W-1:0] aw_addr,
   input logic              w_valid,
   input logic [FCNT_W-1:0] in_cnt,
   input logic [FCNT_W-1:0] out_cnt
);
   assert_ar_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr));

   assert_aw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr));

   assert_wr_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      aw_valid |-> out_cnt >= FCNT_W'(BEATS));

   assert_rd_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ar_valid |-> in_cnt <= FCNT_W'(FIFO_DEPTH - BEATS));

   assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done && !busy);

   assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy && !done);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ar_valid && !aw_valid && !w_valid);
endmodule

bind strm_fir_dma strm_fir_dma_chk #(
   .ADDR_W    (ADDR_W),
   .BEATS     (BEATS),
   .FIFO_DEPTH(FIFO_DEPTH),
   .FCNT_W    (FCNT_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .err     (err),
   .irq     (irq),
   .ar_valid(ar_valid),
   .ar_ready(ar_ready),
   .ar_addr (ar_addr),
   .aw_valid(aw_valid),
   .aw_ready(aw_ready),
   .aw_addr (aw_addr),
   .w_valid (w_valid),
   .in_cnt  (in_cnt),
   .out_cnt (out_cnt)
);

// File: tb/strm_fir_dma_tb.sv
`timescale 1ns/1ps
module strm_fir_dma_tb;
   localparam logic [31:0] SRC = 32'h0001_0000;
   localparam logic [31:0] DST = 32'h0004_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [21:0] xfer_bytes = '0;
   logic        rev_order = 1'b0;
   logic [7:0]  pass_total = '0;
   logic        busy, done, err, irq;
   logic [31:0] cycles;
   logic        ar_valid, ar_ready, r_valid, r_ready, r_last;
   logic [31:0] ar_addr, aw_addr;
   logic [63:0] r_data, w_data;
   logic        aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   strm_fir_dma u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .src_base(SRC), .dst_base(DST),
      .xfer_bytes(xfer_bytes), .rev_order(rev_order), .pass_total(pass_total),
      .busy(busy), .done(done), .err(err), .irq(irq), .cycles(cycles),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
      .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
      .b_valid(b_valid), .b_ready(b_ready)
   );

   // ---------------- memory responder ----------------
   logic [63:0] src_mem [0:511];
   logic [63:0] dst_mem [0:511];
   logic [31:0] ar_log  [0:127];
   logic [31:0] rd_ptr, wr_ptr;
   logic [4:0]  rd_left;
   logic        wr_act, bpend;
   logic [7:0]  lfsr;
   logic        stall_en = 1'b0;
   logic        hold_aw = 1'b0;
   logic        tb_clear = 1'b0;
   int          ar_n, aw_n, w_n, wl_n, irq_n;

   assign ar_ready = (rd_left == 0) && !(stall_en && lfsr[0]);
   assign r_valid  = (rd_left != 0) && !(stall_en && lfsr[1]);
   assign r_data   = src_mem[rd_ptr[11:3]];
   assign r_last   = (rd_left == 5'd1);
   assign aw_ready = !wr_act && !bpend && !hold_aw && !(stall_en && lfsr[2]);
   assign w_ready  = wr_act && !(stall_en && lfsr[3]);
   assign b_valid  = bpend && !(stall_en && lfsr[4]);

   always @(posedge clk) begin
      if (!rst_n) begin
         rd_left <= '0; rd_ptr <= '0; wr_ptr <= '0; wr_act <= 1'b0; bpend <= 1'b0;
         lfsr <= 8'hA5; ar_n <= 0; aw_n <= 0; w_n <= 0; wl_n <= 0; irq_n <= 0;
      end else begin
         lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         if (tb_clear) begin
            ar_n <= 0; aw_n <= 0; w_n <= 0; wl_n <= 0; irq_n <= 0;
            for (int i = 0; i < 512; i++) dst_mem[i] <= '0;
         end
         if (ar_valid && ar_ready) begin
            if (ar_n < 128) ar_log[ar_n] <= ar_addr;
            ar_n <= ar_n + 1; rd_ptr <= ar_addr; rd_left <= 5'd16;
         end
         if (r_valid && r_ready) begin
            rd_ptr <= rd_ptr + 32'd8; rd_left <= rd_left - 5'd1;
         end
         if (aw_valid && aw_ready) begin
            wr_ptr <= aw_addr; wr_act <= 1'b1; aw_n <= aw_n + 1;
         end
         if (w_valid && w_ready) begin
            dst_mem[wr_ptr[11:3]] <= w_data;
            wr_ptr <= wr_ptr + 32'd8; w_n <= w_n + 1;
            if (w_last) begin wr_act <= 1'b0; bpend <= 1'b1; wl_n <= wl_n + 1; end
         end
         if (b_valid && b_ready) bpend <= 1'b0;
         if (irq) irq_n <= irq_n + 1;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int pmap(input int j, input int k, input bit rev);
      int r = 0;
      if (!rev) return j;
      for (int b = 0; b < k; b++) r |= ((j >> b) & 1) << (k - 1 - b);
      return r;
   endfunction

   task automatic fill_src(input int seed);
      for (int i = 0; i < 512; i++)
         for (int b = 0; b < 8; b++)
            src_mem[i][b*8 +: 8] = 8'(((i * 8 + b) * 37 + seed * 11) ^ (i >> 1));
   endtask

   task automatic clear_log;
      @(negedge clk); tb_clear = 1'b1;
      @(negedge clk); tb_clear = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(busy == 0 && done == 0 && err == 0 && irq == 0, "R1", "status after reset", {busy, done, err, irq}, 0);
      chk(ar_valid == 0 && aw_valid == 0 && w_valid == 0, "R1", "bus idle after reset", {ar_valid, aw_valid, w_valid}, 0);
      chk(cycles == 0, "R1", "cycles after reset", cycles, 0);
   endtask

   task automatic t_bad_size(input int size);
      clear_log();
      xfer_bytes = 22'(size); pass_total = 8'd1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(err == 1, "R11", $sformatf("err for length %0d", size), err, 1);
      repeat (5) @(negedge clk);
      chk(busy == 0 && done == 0, "R11", "no run after illegal length", {busy, done}, 0);
      chk(ar_n == 0, "R11", "no read after illegal length", ar_n, 0);
   endtask

   task automatic t_run(input int size, input bit rev, input int passes, input bit stall,
                        input bit block_wr, input bit restart_mid, input int seed);
      int npk, k, n, exp_bursts, bad, first_bad_act, first_bad_exp;
      int h1, h2, h3, x, y, p;
      npk = size / 128; k = $clog2(npk);
      exp_bursts = npk * ((passes == 0) ? 1 : passes);
      fill_src(seed); stall_en = stall; hold_aw = block_wr;
      clear_log();
      xfer_bytes = 22'(size); rev_order = rev; pass_total = 8'(passes); start = 1'b1;
      @(posedge clk); @(negedge clk); start = 1'b0;
      chk(busy == 1 && err == 0, "R2", "busy after accepted start", {busy, err}, 2);
      n = 0;
      while (!done && n < 40000) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (restart_mid && n == 20) begin
            // R12: second start with altered configuration mid-run
            rev_order = !rev; xfer_bytes = 22'(4096); start = 1'b1;
            @(posedge clk); n++; @(negedge clk); start = 1'b0;
         end
         if (block_wr && n == 400) begin
            chk(ar_n == 4, "R7", "read bursts accepted while writes blocked", ar_n, 4);
            hold_aw = 1'b0;
         end
      end
      chk(done == 1, "R9", "done reached before watchdog", done, 1);
      chk(cycles == 32'(n), "R10", "elapsed cycles at done", cycles, n);
      chk(busy == 0, "R9", "busy low at done", busy, 0);
      repeat (2) @(negedge clk);
      chk(irq_n == 1 && irq == 0, "R9", "single irq pulse", irq_n, 1);
      chk(ar_n == exp_bursts, "R8", "read bursts in run", ar_n, exp_bursts);
      chk(aw_n == exp_bursts && wl_n == exp_bursts && w_n == 16 * exp_bursts,
          "R6", "write bursts/beats", w_n, 16 * exp_bursts);
      bad = 0; first_bad_act = 0; first_bad_exp = 0;
      for (int i = 0; i < ar_n && i < 128; i++) begin
         int ea;
         ea = int'(SRC) + pmap(i % npk, k, rev) * 128;
         if (int'(ar_log[i]) != ea) begin
            if (bad == 0) begin first_bad_act = int'(ar_log[i]); first_bad_exp = ea; end
            bad++;
         end
      end
      chk(bad == 0, rev ? "R4" : "R3", "read burst address order", first_bad_act, first_bad_exp);
      bad = 0; h1 = 0; h2 = 0; h3 = 0;
      for (int j = 0; j < npk; j++) begin
         p = pmap(j, k, rev);
         for (int b = 0; b < 16; b++)
            for (int l = 0; l < 8; l++) begin
               x = int'(src_mem[p * 16 + b][l*8 +: 8]);
               y = (x + 3 * h1 + 3 * h2 + h3) >> 3;
               if (y > 255) y = 255;
               h3 = h2; h2 = h1; h1 = x;
               if (int'(dst_mem[p * 16 + b][l*8 +: 8]) != y) begin
                  if (bad == 0) begin
                     first_bad_act = int'(dst_mem[p * 16 + b][l*8 +: 8]); first_bad_exp = y;
                  end
                  bad++;
               end
            end
      end
      chk(bad == 0, "R5", $sformatf("filtered bytes (len %0d rev %0d passes %0d)", size, rev, passes),
          first_bad_act, first_bad_exp);
      stall_en = 1'b0;
   endtask

   // ---------------- sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bad_size(768);
      t_bad_size(64);
      t_bad_size(0);
      t_run(128, 1'b0, 1, 1'b0, 1'b0, 1'b0, 1);
      chk(err == 0, "R11", "legal start clears err", err, 0);
      t_run(4096, 1'b0, 1, 1'b1, 1'b1, 1'b0, 2);
      t_run(4096, 1'b1, 1, 1'b0, 1'b0, 1'b0, 3);
      t_run(512, 1'b1, 3, 1'b1, 1'b0, 1'b1, 4);
      t_run(256, 1'b0, 0, 1'b0, 1'b0, 1'b0, 5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule